// File: doc/BRIEF.md
# Half-Bridge Gate Dead-Band Generator

This block converts a single PWM command bit into two gate enables, one for the upper switch and one for the lower switch of a half-bridge. Whenever the command changes, the conducting switch is released at once. Its partner is switched on only after a blanking interval has passed with no further command change. This keeps the two switches from ever conducting together, so no shoot-through current can flow through the leg.

The blanking interval is counted in clock cycles. It starts from a base value set by a parameter. A 2-bit load-current level input shortens it in fixed steps, which cuts switching losses when the load current is high. A floor value limits how short the interval can become. An enable input and a fault input both force the two gates off in the same cycle. When operation resumes, the gates stay off for one full interval before either is switched on. The PWM command, enable, fault and level are plain control pins with no handshake. The block never stalls the command, and it applies no back-pressure.

With the default parameters and a 50 MHz clock, the intervals are 2 µs at level 0, 1.5 µs at level 1, and 1 µs at levels 2 and 3.

Top module: `gate_deadband`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in the same cycle.
- R2: In the first cycle after the clock edge at which a change of `pwm_cmd` is sampled, both gates are 0.
- R3: After a command change is sampled at edge t, both gates stay 0 through edge t+D-1. At edge t+D the gate that matches the new command turns on. D is the interval chosen at edge t.
- R4: D = max(BASE_CYC - lvl*STEP_CYC, FLOOR_CYC). Here lvl is the unsigned value of `load_lvl`. With the defaults (100, 25, 50), codes 0, 1, 2 and 3 give 100, 75, 50 and 50 cycles.
- R5: A command change sampled while an interval is still running restarts the full interval. Neither gate turns on until D cycles have passed after the latest change.
- R6: `load_lvl` is sampled only when an interval starts. A change of `load_lvl` while an interval is running does not alter that interval.
- R7: While `fault` is 1 or `enable` is 0, both gates are 0. This holds combinationally, in the same cycle the input changes.
- R8: When `enable` is 1 and `fault` is 0 again, both gates stay 0 for D cycles, counted from the first edge that samples the run condition.
- R9: While `rst` is 1, both gates are 0. After `rst` is released, both gates stay 0 for D cycles before the first gate turns on.
- R10: Once an interval has elapsed with no further change, `gate_hi` equals `pwm_cmd` and `gate_lo` equals its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | PWM command: 1 selects the upper switch, 0 the lower |
| enable | input | 1 | Run enable; 0 forces both gates off |
| fault | input | 1 | Fault stop; 1 forces both gates off |
| load_lvl | input | LVL_W | Load-current level code that shortens the interval |
| gate_hi | output | 1 | Upper switch gate enable |
| gate_lo | output | 1 | Lower switch gate enable |

## Verification
The bench measures the exact count of blanked cycles after command changes, reset release, and the end of an enable or fault condition. A counter off by one cycle in either direction therefore shows up as a wrong count. It toggles the command again partway through an interval. A design that kept the old count running, rather than restarting it, would turn a gate on too early. It changes the level code in the middle of an interval and drives every code, including the one that would fall below the floor. This catches an interval that follows the live level or fails to clamp. It also checks that a fault drops both gates in the same cycle and that no cycle ever has both gates on.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

  // Blanking length for one level code, clamped at the floor
  function automatic int dt_for_code(int base, int flr, int step, int code);
    int v;
    v = base - code * step;
    if (v < flr) v = flr;
    return v;
  endfunction

endpackage

// File: rtl/gdb_interval.sv
module gdb_interval #(
  parameter int BASE_CYC  = 100,
  parameter int FLOOR_CYC = 50,
  parameter int STEP_CYC  = 25,
  parameter int LVL_W     = 2,
  parameter int CNT_W     = 7
) (
  input  logic [LVL_W-1:0] lvl_i,
  output logic [CNT_W-1:0] dt_o
);
  localparam int NCODE = 2 ** LVL_W;

  logic [CNT_W-1:0] tbl [NCODE];

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    assign tbl[c] = CNT_W'(gdb_pkg::dt_for_code(BASE_CYC, FLOOR_CYC, STEP_CYC, c));
  end

  assign dt_o = tbl[lvl_i];

  // R4
  always_comb begin
    floor_chk: assert (int'(dt_o) >= FLOOR_CYC && int'(dt_o) <= BASE_CYC);
  end
endmodule

// File: rtl/gdb_blank_timer.sv
module gdb_blank_timer #(
  parameter int BASE_CYC = 100,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] dt_i,
  output logic             settled_o
);
  logic             cmd_prev_q;
  logic             arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             toggle;
  logic             load;

  assign toggle    = cmd_i ^ cmd_prev_q;
  assign load      = run_i & (arm_q | toggle);
  assign settled_o = run_i & ~load & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_prev_q <= 1'b0;
      arm_q      <= 1'b1;
      cnt_q      <= '0;
    end else begin
      cmd_prev_q <= cmd_i;
      if (!run_i) begin
        arm_q <= 1'b1;
      end else if (load) begin
        arm_q <= 1'b0;
        cnt_q <= dt_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < BASE_CYC);

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !settled_o);
endmodule

// File: rtl/gdb_drive.sv
module gdb_drive (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic settled_i,
  input  logic cmd_i,
  output logic hi_o,
  output logic lo_o
);
  logic hi_q;
  logic lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (settled_i) begin
      hi_q <= cmd_i;
      lo_q <= ~cmd_i;
    end else begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end
  end

  assign hi_o = hi_q & run_i;
  assign lo_o = lo_q & run_i;

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_o && lo_o));

  // R10
  hi_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hi_o |-> $past(cmd_i));

  // R10
  lo_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lo_o |-> !$past(cmd_i));
endmodule

// File: rtl/gate_deadband.sv
module gate_deadband #(
  parameter int BASE_CYC  = 100,
  parameter int FLOOR_CYC = 50,
  parameter int STEP_CYC  = 25,
  parameter int LVL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_cmd,
  input  logic             enable,
  input  logic             fault,
  input  logic [LVL_W-1:0] load_lvl,
  output logic             gate_hi,
  output logic             gate_lo
);
  localparam int CNT_W = $clog2(BASE_CYC + 1);

  logic             run;
  logic             settled;
  logic [CNT_W-1:0] dt;

  assign run = enable & ~fault;

  gdb_interval #(
    .BASE_CYC (BASE_CYC),
    .FLOOR_CYC(FLOOR_CYC),
    .STEP_CYC (STEP_CYC),
    .LVL_W    (LVL_W),
    .CNT_W    (CNT_W)
  ) u_interval (
    .lvl_i(load_lvl),
    .dt_o (dt)
  );

  gdb_blank_timer #(
    .BASE_CYC(BASE_CYC),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .cmd_i    (pwm_cmd),
    .dt_i     (dt),
    .settled_o(settled)
  );

  gdb_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .settled_i(settled),
    .cmd_i    (pwm_cmd),
    .hi_o     (gate_hi),
    .lo_o     (gate_lo)
  );

  // R2
  edge_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_cmd != $past(pwm_cmd)) |=> (!gate_hi && !gate_lo));

  // R8
  resume_low_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |=> (!gate_hi && !gate_lo));

  // R7
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!gate_hi && !gate_lo));
endmodule

// File: tb/test_gate_deadband.sv
module test_gate_deadband;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_cmd = 1'b0;
  logic       enable = 1'b1;
  logic       fault = 1'b0;
  logic [1:0] load_lvl = 2'd0;
  logic       gate_hi;
  logic       gate_lo;

  int tests  = 0;
  int fails  = 0;
  int overlap = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gate_deadband i_gate_deadband (
    .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .enable(enable),
    .fault(fault), .load_lvl(load_lvl), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always @(negedge clk) if (gate_hi && gate_lo) overlap++;

  function automatic int exp_dt(int lvl);
    int v = 100 - 25 * lvl;
    return (v < 50) ? 50 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedge samples with both gates low, stops at first assertion
  task automatic measure(output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!gate_hi && !gate_lo) n++;
      else break;
    end
  endtask

  task automatic check_steady(string req);
    check(gate_hi == pwm_cmd && gate_lo == !pwm_cmd, req,
          {gate_hi, gate_lo}, {pwm_cmd, !pwm_cmd});
  endtask

  task automatic t_reset();
    int n;
    repeat (4) @(negedge clk);
    check(!gate_hi && !gate_lo, "R9 low in reset", {gate_hi, gate_lo}, 0);
    rst = 1'b0;
    measure(n);
    check(n == exp_dt(0), "R9 blank after reset", n, exp_dt(0));
    check_steady("R10 lower on after reset");
  endtask

  task automatic t_toggle();
    int n;
    pwm_cmd = 1'b1;
    @(negedge clk);
    check(!gate_hi && !gate_lo, "R2 both off after change", {gate_hi, gate_lo}, 0);
    measure(n);
    check(n + 1 == exp_dt(0), "R3 rise interval", n + 1, exp_dt(0));
    check_steady("R10 upper on");
    pwm_cmd = 1'b0;
    measure(n);
    check(n == exp_dt(0), "R3 fall interval", n, exp_dt(0));
    check_steady("R10 lower on");
  endtask

  task automatic t_levels();
    int n;
    for (int l = 1; l < 4; l++) begin
      load_lvl = 2'(l);
      pwm_cmd  = ~pwm_cmd;
      measure(n);
      check(n == exp_dt(l), "R4 level interval", n, exp_dt(l));
      check_steady("R10 after level interval");
    end
    load_lvl = 2'd0;
  endtask

  task automatic t_restart();
    int n;
    pwm_cmd = ~pwm_cmd;
    repeat (30) @(negedge clk);
    pwm_cmd = ~pwm_cmd;
    measure(n);
    check(n == exp_dt(0), "R5 restarted interval", n, exp_dt(0));
    check_steady("R5 follows latest command");
  endtask

  task automatic t_midlvl();
    int n;
    load_lvl = 2'd0;
    pwm_cmd  = ~pwm_cmd;
    repeat (10) @(negedge clk);
    load_lvl = 2'd2;
    measure(n);
    check(n + 10 == exp_dt(0), "R6 level change mid interval", n + 10, exp_dt(0));
    load_lvl = 2'd0;
  endtask

  task automatic t_fault();
    int n;
    check_steady("R10 steady before fault");
    fault = 1'b1;
    #1;
    check(!gate_hi && !gate_lo, "R7 fault drops gates", {gate_hi, gate_lo}, 0);
    repeat (5) @(negedge clk);
    fault = 1'b0;
    measure(n);
    check(n == exp_dt(0), "R8 blank after fault", n, exp_dt(0));
    check_steady("R10 after fault");
  endtask

  task automatic t_enable();
    int n;
    load_lvl = 2'd1;
    enable = 1'b0;
    #1;
    check(!gate_hi && !gate_lo, "R7 disable drops gates", {gate_hi, gate_lo}, 0);
    repeat (3) @(negedge clk);
    pwm_cmd = ~pwm_cmd;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    measure(n);
    check(n == exp_dt(1), "R8 blank after enable", n, exp_dt(1));
    check_steady("R10 after enable");
    load_lvl = 2'd0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R3 watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_toggle();
    t_levels();
    t_restart();
    t_midlvl();
    t_fault();
    t_enable();
    check(overlap == 0, "R1 no overlap seen", overlap, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule